// File: doc/BRIEF.md
# Bidirectional Doorbell Interrupt Mailbox

This block passes short notification words between a host bus and an embedded I/O processor that share one clock. Each side owns a small four-word register window. A write to its send word stores a 32-bit doorbell value. The same write marks that value pending toward the other side. The receiver reads the value from its own window. It raises a maskable interrupt when unmasked. It drops the pending flag by writing any data word to its acknowledge location.

The two directions are separate. Each has its own value register, pending flag, mask bit and interrupt line. A sender can watch its status word to see whether its last message has been acknowledged yet. Register reads are combinational from the current state. A write takes effect at the next clock edge.

Top module: `doorbell_mailbox`

## Requirements
- R1: After reset, both doorbell values read 0, neither direction is pending, both mask bits read 1 and both interrupt outputs are low.
- R2: A host write to host offset 0 stores the data as the host-to-IOP doorbell and sets it pending. From the next cycle, the IOP reads that value at IOP offset 1.
- R3: An IOP write to IOP offset 0 stores the data as the IOP-to-host doorbell and sets it pending. From the next cycle, the host reads that value at host offset 1.
- R4: A write of any data to offset 1 on the receiving side clears the pending flag of the incoming direction. It leaves the stored value unchanged.
- R5: Offset 2 on each side holds the mask for that side's incoming interrupt in bit 0, where 1 means masked. Each interrupt output is high exactly when its direction is pending and its mask bit is 0.
- R6: Setting or clearing a mask never changes the pending flag. Unmasking while a message is pending raises the interrupt on the next cycle.
- R7: If a send and an acknowledge of the same direction occur in the same cycle, the pending flag stays set and the value becomes the newly sent data.
- R8: Offset 3 on each side is a read-only status word. Bit 0 is the incoming pending flag and bit 1 is the pending flag of the side's own outgoing message. The upper bits are 0 and writes to this offset change nothing.
- R9: Offset 0 read back returns the last value the side sent. A stored value changes only when its sender writes offset 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| iop_we | input | 1 | IOP register write strobe |
| iop_addr | input | 2 | IOP word offset |
| iop_wdata | input | 32 | IOP write data |
| iop_rdata | output | 32 | IOP read data for iop_addr |
| irq_to_iop | output | 1 | Interrupt toward the IOP |
| irq_to_host | output | 1 | Interrupt toward the host |

## Verification
A corrupted pending flag shows up one cycle after the write that caused it, in two places. One is the receiver's interrupt, when unmasked. The other is both sides' status words, which disagree with the expected bits. A wrong stored value appears on the receiver's offset 1 and the sender's offset 0 the cycle after the send. A reference model compares every read port and both interrupts on every clock, so any divergence is reported in the cycle it first becomes visible. This includes the same-cycle send/acknowledge collision.

// File: rtl/doorbell_pkg.sv
package doorbell_pkg;
  localparam int unsigned DB_ADDR_W = 2;
  typedef enum logic [DB_ADDR_W-1:0] {
    OFS_SEND = 2'd0,
    OFS_RECV = 2'd1,
    OFS_MASK = 2'd2,
    OFS_STAT = 2'd3
  } db_ofs_e;
  localparam int unsigned DB_SIDES = 2;
endpackage

// File: rtl/db_channel.sv
module db_channel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              send_we,
  input  logic [DATA_W-1:0] send_data,
  input  logic              ack_we,
  input  logic              mask_we,
  input  logic              mask_bit,
  output logic [DATA_W-1:0] value,
  output logic              pending,
  output logic              masked,
  output logic              irq
);
  logic [DATA_W-1:0] value_q, value_d;
  logic              pend_q, pend_d, pend_en;
  logic              mask_q, mask_d;

  always_comb begin
    value_d = send_data;
    pend_en = send_we | ack_we;
    pend_d  = send_we;
    mask_d  = mask_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      value_q <= '0;
      pend_q  <= 1'b0;
      mask_q  <= 1'b1;
    end else begin
      if (send_we) value_q <= value_d;
      if (pend_en) pend_q  <= pend_d;
      if (mask_we) mask_q  <= mask_d;
    end
  end

  assign value   = value_q;
  assign pending = pend_q;
  assign masked  = mask_q;
  assign irq     = pend_q & ~mask_q;

  p_send_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    send_we |=> (pending && value == $past(send_data)));
  p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && !send_we) |=> !pending);
  p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && send_we) |=> pending);
  p_mask_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!send_we && !ack_we) |=> $stable(pending));
  p_value_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !send_we |=> $stable(value));
  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    masked |-> !irq);
endmodule

// File: rtl/db_regport.sv
module db_regport
  import doorbell_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 we,
  input  logic [DB_ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    out_value,
  input  logic                 out_pending,
  input  logic [DATA_W-1:0]    in_value,
  input  logic                 in_pending,
  input  logic                 in_mask,
  output logic                 send_we,
  output logic                 ack_we,
  output logic                 mask_we,
  output logic [DATA_W-1:0]    rdata
);
  always_comb begin
    send_we = we && (addr == OFS_SEND);
    ack_we  = we && (addr == OFS_RECV);
    mask_we = we && (addr == OFS_MASK);
    unique case (db_ofs_e'(addr))
      OFS_SEND: rdata = out_value;
      OFS_RECV: rdata = in_value;
      OFS_MASK: rdata = {{(DATA_W-1){1'b0}}, in_mask};
      default:  rdata = {{(DATA_W-2){1'b0}}, out_pending, in_pending};
    endcase
  end
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
  import doorbell_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_we,
  input  logic [DB_ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0]    host_wdata,
  output logic [DATA_W-1:0]    host_rdata,
  input  logic                 iop_we,
  input  logic [DB_ADDR_W-1:0] iop_addr,
  input  logic [DATA_W-1:0]    iop_wdata,
  output logic [DATA_W-1:0]    iop_rdata,
  output logic                 irq_to_iop,
  output logic                 irq_to_host
);
  // side 0 = host, side 1 = IOP; direction d is sent by side d
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic                 s_we    [DB_SIDES];
  logic [DB_ADDR_W-1:0] s_addr  [DB_SIDES];
  logic [DATA_W-1:0]    s_wdata [DB_SIDES];
  logic [DATA_W-1:0]    s_rdata [DB_SIDES];
  logic                 s_send  [DB_SIDES];
  logic                 s_ack   [DB_SIDES];
  logic                 s_mask  [DB_SIDES];
  logic [DATA_W-1:0]    d_value [DB_SIDES];
  logic                 d_pend  [DB_SIDES];
  logic                 d_mask  [DB_SIDES];
  logic                 d_irq   [DB_SIDES];

  assign s_we[0]    = host_we;
  assign s_addr[0]  = host_addr;
  assign s_wdata[0] = host_wdata;
  assign s_we[1]    = iop_we;
  assign s_addr[1]  = iop_addr;
  assign s_wdata[1] = iop_wdata;

  for (genvar g = 0; g < DB_SIDES; g++) begin : g_side
    localparam int unsigned PEER = DB_SIDES - 1 - g;

    db_regport #(.DATA_W(DATA_W)) u_port (
      .we          (s_we[g]),
      .addr        (s_addr[g]),
      .wdata       (s_wdata[g]),
      .out_value   (d_value[g]),
      .out_pending (d_pend[g]),
      .in_value    (d_value[PEER]),
      .in_pending  (d_pend[PEER]),
      .in_mask     (d_mask[PEER]),
      .send_we     (s_send[g]),
      .ack_we      (s_ack[g]),
      .mask_we     (s_mask[g]),
      .rdata       (s_rdata[g])
    );

    db_channel #(.DATA_W(DATA_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .send_we   (s_send[g]),
      .send_data (s_wdata[g]),
      .ack_we    (s_ack[PEER]),
      .mask_we   (s_mask[PEER]),
      .mask_bit  (s_wdata[PEER][0]),
      .value     (d_value[g]),
      .pending   (d_pend[g]),
      .masked    (d_mask[g]),
      .irq       (d_irq[g])
    );
  end

  assign host_rdata  = s_rdata[0];
  assign iop_rdata   = s_rdata[1];
  assign irq_to_iop  = d_irq[0];
  assign irq_to_host = d_irq[1];

  p_stat_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_we && host_addr == 2'd3 && !iop_we) |=> ($stable(irq_to_iop) && $stable(irq_to_host)));
  p_host_send_irq_r2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (host_we && host_addr == 2'd0 && !d_mask[0] && !(iop_we && iop_addr == 2'd2)) |=> irq_to_iop);
endmodule

// File: tb/doorbell_mailbox_test.sv
module doorbell_mailbox_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_we, iop_we;
  logic [1:0]  host_addr, iop_addr;
  logic [31:0] host_wdata, iop_wdata, host_rdata, iop_rdata;
  logic        irq_to_iop, irq_to_host;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  doorbell_mailbox uut (
    .clk(clk), .rst_n(rst_n),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .iop_we(iop_we), .iop_addr(iop_addr), .iop_wdata(iop_wdata), .iop_rdata(iop_rdata),
    .irq_to_iop(irq_to_iop), .irq_to_host(irq_to_host)
  );

  // reference model: index 0 = host->IOP direction, 1 = IOP->host
  logic [31:0] m_val [2];
  bit          m_pend [2];
  bit          m_mask [2];
  int          rst_cnt;

  function automatic logic [31:0] model_read(int side, logic [1:0] a);
    int o = side;
    int i = 1 - side;
    case (a)
      2'd0: return m_val[o];
      2'd1: return m_val[i];
      2'd2: return {31'd0, m_mask[i]};
      default: return {30'd0, m_pend[o], m_pend[i]};
    endcase
  endfunction

  always @(posedge clk) begin
    bit         we [2];
    logic [1:0] ad [2];
    logic [31:0] wd [2];
    bit         nsend [2];
    bit         nack [2];
    we[0] = host_we; ad[0] = host_addr; wd[0] = host_wdata;
    we[1] = iop_we;  ad[1] = iop_addr;  wd[1] = iop_wdata;
    if (!rst_n || rst_cnt < 2) begin
      for (int k = 0; k < 2; k++) begin
        m_val[k] = 32'd0; m_pend[k] = 0; m_mask[k] = 1;
      end
      rst_cnt = rst_n ? rst_cnt + 1 : 0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        nsend[s] = we[s] && ad[s] == 2'd0;
        nack[1-s] = we[s] && ad[s] == 2'd1;
      end
      for (int s = 0; s < 2; s++) begin
        if (we[s] && ad[s] == 2'd2) m_mask[1-s] = wd[s][0];
      end
      for (int d = 0; d < 2; d++) begin
        if (nsend[d]) begin
          m_val[d] = wd[d]; m_pend[d] = 1;
        end else if (nack[d]) m_pend[d] = 0;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R9 host_rdata vs model", host_rdata, model_read(0, host_addr));
      chk("R9 iop_rdata vs model", iop_rdata, model_read(1, iop_addr));
      chk("R5 irq_to_iop vs model", {31'd0, irq_to_iop}, {31'd0, m_pend[0] & ~m_mask[0]});
      chk("R5 irq_to_host vs model", {31'd0, irq_to_host}, {31'd0, m_pend[1] & ~m_mask[1]});
    end
  end

  task automatic drive(bit hw, logic [1:0] ha, logic [31:0] hd, bit iw, logic [1:0] ia, logic [31:0] id);
    @(negedge clk);
    host_we = hw; host_addr = ha; host_wdata = hd;
    iop_we = iw;  iop_addr = ia;  iop_wdata = id;
  endtask

  task automatic look(logic [1:0] ha, logic [1:0] ia);
    drive(0, ha, 32'd0, 0, ia, 32'd0);
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0;
    host_we = 0; host_addr = 0; host_wdata = 0;
    iop_we = 0; iop_addr = 0; iop_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    look(2'd2, 2'd2);
    chk("R1 host mask", host_rdata, 32'd1);
    chk("R1 iop mask", iop_rdata, 32'd1);
    chk("R1 irqs", {30'd0, irq_to_iop, irq_to_host}, 32'd0);
    look(2'd0, 2'd1);
    chk("R1 host value", host_rdata, 32'd0);
    chk("R1 iop value", iop_rdata, 32'd0);

    // R2 host sends, masked
    drive(1, 2'd0, 32'hA5A5_0001, 0, 2'd0, 32'd0);
    look(2'd3, 2'd1);
    chk("R2 iop reads value", iop_rdata, 32'hA5A5_0001);
    chk("R8 host status outgoing", host_rdata, 32'd2);
    chk("R5 masked irq low", {31'd0, irq_to_iop}, 32'd0);
    // R5 unmask
    drive(0, 2'd0, 32'd0, 1, 2'd2, 32'hFFFF_FFFE);
    look(2'd0, 2'd3);
    chk("R5 irq_to_iop high", {31'd0, irq_to_iop}, 32'd1);
    chk("R8 iop status incoming", iop_rdata, 32'd1);
    chk("R9 host reads own sent", host_rdata, 32'hA5A5_0001);
    // R6 remask keeps pending
    drive(0, 2'd0, 32'd0, 1, 2'd2, 32'd1);
    look(2'd0, 2'd3);
    chk("R6 irq low when masked", {31'd0, irq_to_iop}, 32'd0);
    chk("R6 pending kept", iop_rdata, 32'd1);
    drive(0, 2'd0, 32'd0, 1, 2'd2, 32'd0);
    look(2'd0, 2'd3);
    chk("R6 unmask raises irq", {31'd0, irq_to_iop}, 32'd1);
    // R8 status write ignored
    drive(1, 2'd3, 32'hFFFF_FFFF, 0, 2'd3, 32'd0);
    look(2'd3, 2'd3);
    chk("R8 status unchanged", iop_rdata, 32'd1);
    chk("R8 host status", host_rdata, 32'd2);
    // R4 ack with arbitrary data
    drive(0, 2'd0, 32'd0, 1, 2'd1, 32'h1234_5678);
    look(2'd3, 2'd1);
    chk("R4 irq cleared", {31'd0, irq_to_iop}, 32'd0);
    chk("R4 value kept", iop_rdata, 32'hA5A5_0001);
    chk("R4 host status clear", host_rdata, 32'd0);

    // R3 IOP sends
    drive(0, 2'd2, 32'd0, 1, 2'd0, 32'hDEAD_BEEF);
    look(2'd1, 2'd3);
    chk("R3 host reads value", host_rdata, 32'hDEAD_BEEF);
    chk("R3 host irq still masked", {31'd0, irq_to_host}, 32'd0);
    chk("R8 iop status outgoing", iop_rdata, 32'd2);
    drive(1, 2'd2, 32'd0, 0, 2'd0, 32'd0);
    look(2'd1, 2'd0);
    chk("R3 irq_to_host high", {31'd0, irq_to_host}, 32'd1);

    // R7 collision: IOP sends while host acks
    drive(1, 2'd1, 32'h0, 1, 2'd0, 32'h0000_0055);
    look(2'd1, 2'd3);
    chk("R7 new value", host_rdata, 32'h0000_0055);
    chk("R7 still pending", {31'd0, irq_to_host}, 32'd1);
    chk("R7 iop outgoing status", iop_rdata, 32'd2);
    // both directions at once
    drive(1, 2'd0, 32'h0BAD_F00D, 1, 2'd0, 32'h600D_CAFE);
    look(2'd1, 2'd1);
    chk("R2 iop reads new", iop_rdata, 32'h0BAD_F00D);
    chk("R3 host reads new", host_rdata, 32'h600D_CAFE);
    chk("R5 both irqs", {30'd0, irq_to_iop, irq_to_host}, 32'd3);
    repeat (3) look(2'd0, 2'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule